// File: doc/BRIEF.md
# Multichannel Analog-Setting Register Controller

This block sits between a simple request interface and a group of transceiver channel register files. Each channel holds six analog settings: output swing, three pre-emphasis taps (one before the main cursor and two after it), equalizer DC gain and equalizer control. A request asks for a write or a readback of a chosen subset of these settings. The controller checks the request, then walks through the selected settings one bus access per cycle. It holds busy while it works and returns the readback as one packed word.

A request can target one channel by its logical address. In the broadcast build, a write goes to every channel instead. A request can also be limited to the receive-side settings, the transmit-side settings, or both. A malformed request never reaches the bus. It is answered with an error pulse of fixed length. The channel count is a multiple of four, and every bus width follows from it.

Top module: `xtc_tune_ctrl`

## Requirements
- R1: During reset and right after it, busy, error, rd_valid, bus_wr and bus_rd are all low.
- R2: A request (req_wr or req_rd high) is accepted only while busy and error are both low, and busy is high in the cycle after acceptance. A request presented while busy is high is ignored and changes no channel.
- R3: Setting layout and addressed writes.
  - Packed settings word layout, LSB first: swing [2:0], pre-tap [7:3], first post-tap [12:8], second post-tap [17:13], DC gain [20:18], equalizer control [24:21].
  - Bus field index: 0 swing, 1 pre-tap, 2 first post-tap, 3 second post-tap, 4 DC gain, 5 equalizer control.
  - Bus write data is the field zero-extended to 5 bits.
  - In addressed mode (BROADCAST=0), a legal write changes only channel req_addr, and busy stays high for exactly 6 cycles.
- R4: In broadcast mode (BROADCAST=1), a legal write goes to every channel and ignores req_addr, and busy stays high for 6*NUM_CH cycles. Reads still use req_addr.
- R5: Field selection.
  - Only fields whose req_fmask bit (bit i = field index i) is set, and whose FIELD_EN bit is set, are written or read.
  - Other fields in the channel are left unchanged.
  - On readback, the positions of unselected fields are zero.
- R6: Scope selection.
  - With SCOPE_EN=1, req_scope selects the sides: 00 both sides, 01 receive only (fields 4 and 5), 10 transmit only (fields 0 to 3), 11 illegal.
  - With SCOPE_EN=0, req_scope is ignored and both sides are always used.
- R7: A legal read keeps busy high for exactly 7 cycles. rd_valid is high for exactly one cycle: the first cycle in which busy is low. In that cycle rd_data carries the packed settings of the addressed channel.
- R8: Illegal requests.
  - A request is illegal if any of these holds: read and write are asserted together; scope 11 is used with SCOPE_EN=1; an address is not below NUM_CH where an address is used; no field is left after masking.
  - An illegal request makes no bus access and leaves busy low.
  - error is high for exactly the two cycles that follow the request.
- R9: The bus never carries a read and a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_wr | input | 1 | Write request strobe |
| req_rd | input | 1 | Readback request strobe |
| req_addr | input | ADDR_W | Logical channel address |
| req_scope | input | 2 | Side selection: 00 both, 01 receive, 10 transmit |
| req_fmask | input | 6 | Per-field enable, bit i = field index i |
| req_wdata | input | 25 | Packed settings to write |
| busy | output | 1 | Access sequence in progress |
| error | output | 1 | Two-cycle pulse for an illegal request |
| rd_valid | output | 1 | One-cycle readback strobe |
| rd_data | output | 25 | Packed readback settings |
| bus_wr | output | 1 | Register file write strobe |
| bus_rd | output | 1 | Register file read strobe |
| bus_ch | output | CH_W | Channel selected on the bus |
| bus_fld | output | 3 | Field index on the bus |
| bus_wdata | output | 5 | Zero-extended field value to write |
| bus_rdata | input | 5 | Field value returned one cycle after bus_rd |

## Verification
The bench drives each request for one cycle on a falling edge. It then samples on the following falling edges.

- **Busy:** it must already be high at the first sample. The bench counts high samples until busy drops, and the count must be 6 for an addressed write, 6*NUM_CH for a broadcast write and 7 for a read.
- **Readback:** at the first low-busy sample, rd_valid and rd_data are compared with a packed word built from a bench shadow of every channel. One sample later the strobe must be low.
- **Illegal requests:** error must be high at the first and second samples and low at the third. The count of bus accesses must be unchanged.
- **Channel contents:** after each write, the contents of the behavioural register files are compared with the shadow.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  localparam int NFLD     = 6;
  localparam int FIDX_W   = 3;
  localparam int FLD_MAXW = 5;
  localparam int SET_W    = 25;
  localparam logic [NFLD-1:0] TX_FIELDS = 6'b001111;
  localparam logic [NFLD-1:0] RX_FIELDS = 6'b110000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_ERR1,
    ST_ERR2
  } seq_state_e;

  function automatic int fld_width(input int idx);
    case (idx)
      0:       return 3;
      1, 2, 3: return 5;
      4:       return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int fld_lsb(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += fld_width(k);
    return acc;
  endfunction
endpackage

// File: rtl/xtc_req_check.sv
module xtc_req_check import xtc_pkg::*; #(
  parameter int              NUM_CH    = 8,
  parameter int              ADDR_W    = 9,
  parameter bit              BROADCAST = 1'b0,
  parameter bit              SCOPE_EN  = 1'b1,
  parameter logic [NFLD-1:0] FIELD_EN  = '1
) (
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_scope,
  input  logic [NFLD-1:0]   req_fmask,
  output logic              legal,
  output logic [NFLD-1:0]   emask
);
  logic [NFLD-1:0] side_mask;
  logic            addr_ok;
  logic            addr_used;
  logic            scope_bad;

  always_comb begin
    side_mask = TX_FIELDS | RX_FIELDS;
    scope_bad = 1'b0;
    if (SCOPE_EN) begin
      case (req_scope)
        2'b00:   side_mask = TX_FIELDS | RX_FIELDS;
        2'b01:   side_mask = RX_FIELDS;
        2'b10:   side_mask = TX_FIELDS;
        default: begin
          side_mask = '0;
          scope_bad = 1'b1;
        end
      endcase
    end
  end

  assign emask     = req_fmask & side_mask & FIELD_EN;
  assign addr_ok   = 32'(req_addr) < 32'(NUM_CH);
  assign addr_used = !BROADCAST || req_rd;
  assign legal     = !(req_wr && req_rd) && !scope_bad &&
                     (!addr_used || addr_ok) && (emask != '0);
endmodule

// File: rtl/xtc_seq.sv
module xtc_seq import xtc_pkg::*; #(
  parameter int NUM_CH    = 8,
  parameter bit BROADCAST = 1'b0,
  parameter int CH_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_bad,
  input  logic              op_rd,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [NFLD-1:0]   emask_in,
  output logic              busy,
  output logic              error,
  output logic              rd_valid,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [CH_W-1:0]   bus_ch,
  output logic [FIDX_W-1:0] bus_fld,
  output logic              cap_en,
  output logic [FIDX_W-1:0] cap_fld
);
  localparam int             EXT_W    = 1 << FIDX_W;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
  localparam logic [FIDX_W-1:0] LAST_FLD = FIDX_W'(NFLD - 1);

  seq_state_e        st_q, st_d;
  logic [FIDX_W-1:0] fld_q, fld_d;
  logic [CH_W-1:0]   ch_q, ch_d, chl_q, chl_d;
  logic              rd_q, rd_d;
  logic [NFLD-1:0]   em_q, em_d;
  logic              pend_q;
  logic [FIDX_W-1:0] pfld_q;
  logic              vld_q;
  logic [EXT_W-1:0]  em_ext;
  logic              access;
  logic              fan_out;

  assign fan_out = BROADCAST && !op_rd;

  always_comb begin
    st_d  = st_q;
    fld_d = fld_q;
    ch_d  = ch_q;
    chl_d = chl_q;
    rd_d  = rd_q;
    em_d  = em_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_RUN;
          fld_d = '0;
          ch_d  = fan_out ? '0 : start_ch;
          chl_d = fan_out ? LAST_CH : start_ch;
          rd_d  = op_rd;
          em_d  = emask_in;
        end else if (start_bad) begin
          st_d = ST_ERR1;
        end
      end
      ST_RUN: begin
        if (fld_q == LAST_FLD) begin
          fld_d = '0;
          if (ch_q == chl_q) st_d = rd_q ? ST_DRAIN : ST_IDLE;
          else               ch_d = ch_q + CH_W'(1);
        end else begin
          fld_d = fld_q + FIDX_W'(1);
        end
      end
      ST_DRAIN: st_d = ST_IDLE;
      ST_ERR1:  st_d = ST_ERR2;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign em_ext  = EXT_W'(em_q);
  assign access  = (st_q == ST_RUN) && em_ext[fld_q];
  assign bus_wr  = access && !rd_q;
  assign bus_rd  = access && rd_q;
  assign bus_ch  = ch_q;
  assign bus_fld = fld_q;
  assign busy    = (st_q == ST_RUN) || (st_q == ST_DRAIN);
  assign error   = (st_q == ST_ERR1) || (st_q == ST_ERR2);
  assign rd_valid = vld_q;
  assign cap_en  = pend_q;
  assign cap_fld = pfld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fld_q  <= '0;
      ch_q   <= '0;
      chl_q  <= '0;
      rd_q   <= 1'b0;
      em_q   <= '0;
      pend_q <= 1'b0;
      pfld_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fld_q  <= fld_d;
      ch_q   <= ch_d;
      chl_q  <= chl_d;
      rd_q   <= rd_d;
      em_q   <= em_d;
      pend_q <= bus_rd;
      pfld_q <= fld_q;
      vld_q  <= (st_q == ST_DRAIN);
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(bus_wr || bus_rd)); // R2
  AST_NO_RDWR: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R9
  AST_VALID_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy))); // R7
  AST_BUSY_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && error)); // R8
  AST_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |=> error); // R8
  AST_ERR_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    (error && $past(error)) |=> !error); // R8
  AST_BAD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (error && !busy)); // R8
endmodule

// File: rtl/xtc_rdback.sv
module xtc_rdback import xtc_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                cap_en,
  input  logic [FIDX_W-1:0]   cap_fld,
  input  logic [FLD_MAXW-1:0] cap_data,
  output logic [SET_W-1:0]    rd_data
);
  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    localparam int W  = fld_width(i);
    localparam int LO = fld_lsb(i);
    logic [W-1:0] q, d;
    always_comb begin
      d = q;
      if (clr)                                          d = '0;
      else if (cap_en && cap_fld == FIDX_W'(i))          d = cap_data[W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign rd_data[LO +: W] = q;
  end
endmodule

// File: rtl/xtc_tune_ctrl.sv
module xtc_tune_ctrl import xtc_pkg::*; #(
  parameter int              NUM_CH    = 8,
  parameter int              ADDR_W    = 9,
  parameter bit              BROADCAST = 1'b0,
  parameter bit              SCOPE_EN  = 1'b1,
  parameter logic [NFLD-1:0] FIELD_EN  = '1,
  localparam int             CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_wr,
  input  logic                req_rd,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_scope,
  input  logic [NFLD-1:0]     req_fmask,
  input  logic [SET_W-1:0]    req_wdata,
  output logic                busy,
  output logic                error,
  output logic                rd_valid,
  output logic [SET_W-1:0]    rd_data,
  output logic                bus_wr,
  output logic                bus_rd,
  output logic [CH_W-1:0]     bus_ch,
  output logic [FIDX_W-1:0]   bus_fld,
  output logic [FLD_MAXW-1:0] bus_wdata,
  input  logic [FLD_MAXW-1:0] bus_rdata
);
  localparam int EXT_N = 1 << FIDX_W;

  logic              legal;
  logic [NFLD-1:0]   emask;
  logic              accept, start, start_bad;
  logic              cap_en;
  logic [FIDX_W-1:0] cap_fld;
  logic [SET_W-1:0]  wd_q, wd_d;
  logic [FLD_MAXW-1:0] fval [EXT_N];

  xtc_req_check #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BROADCAST(BROADCAST),
    .SCOPE_EN(SCOPE_EN), .FIELD_EN(FIELD_EN)
  ) u_chk (
    .req_wr(req_wr), .req_rd(req_rd), .req_addr(req_addr),
    .req_scope(req_scope), .req_fmask(req_fmask),
    .legal(legal), .emask(emask)
  );

  assign accept    = (req_wr || req_rd) && !busy && !error;
  assign start     = accept && legal;
  assign start_bad = accept && !legal;

  xtc_seq #(.NUM_CH(NUM_CH), .BROADCAST(BROADCAST), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_bad(start_bad),
    .op_rd(req_rd), .start_ch(req_addr[CH_W-1:0]), .emask_in(emask),
    .busy(busy), .error(error), .rd_valid(rd_valid),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ch(bus_ch), .bus_fld(bus_fld),
    .cap_en(cap_en), .cap_fld(cap_fld)
  );

  always_comb begin
    wd_d = wd_q;
    if (start && req_wr) wd_d = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= '0;
    else        wd_q <= wd_d;
  end

  for (genvar i = 0; i < EXT_N; i++) begin : g_wsel
    if (i < NFLD) begin : g_real
      assign fval[i] = FLD_MAXW'(wd_q[fld_lsb(i) +: fld_width(i)]);
    end else begin : g_pad
      assign fval[i] = '0;
    end
  end
  assign bus_wdata = fval[bus_fld];

  xtc_rdback u_rb (
    .clk(clk), .rst_n(rst_n), .clr(start && req_rd),
    .cap_en(cap_en), .cap_fld(cap_fld), .cap_data(bus_rdata),
    .rd_data(rd_data)
  );

  AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> (32'(bus_ch) < 32'(NUM_CH))); // R3
  AST_ABSENT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |-> FIELD_EN[bus_fld]); // R5
endmodule

// File: tb/tb_xtc_tune_ctrl.sv
module tb_chan_model #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bwr,
  input  logic          brd,
  input  logic [CW-1:0] ch,
  input  logic [2:0]    fld,
  input  logic [4:0]    wd,
  output logic [4:0]    rd
);
  logic [4:0] mem [NCH][8];
  int n_acc;
  int n_both;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++)
        for (int f = 0; f < 8; f++) mem[c][f] <= '0;
      rd     <= '0;
      n_acc  <= 0;
      n_both <= 0;
    end else begin
      if (bwr) mem[ch][fld] <= wd;
      if (brd) rd <= mem[ch][fld];
      if (bwr || brd) n_acc <= n_acc + 1;
      if (bwr && brd) n_both <= n_both + 1;
    end
  end
endmodule

module tb_xtc_tune_ctrl;
  localparam int NA = 8;
  localparam int NB = 4;
  localparam int AW = 9;
  localparam int SW = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic a_wr, a_rd, a_busy, a_err, a_vld, a_bwr, a_brd;
  logic [AW-1:0] a_addr;
  logic [1:0] a_scope;
  logic [5:0] a_fm;
  logic [SW-1:0] a_wd, a_rdat;
  logic [2:0] a_bch, a_bfld;
  logic [4:0] a_bwd, a_brdat;

  logic b_wr, b_rd, b_busy, b_err, b_vld, b_bwr, b_brd;
  logic [AW-1:0] b_addr;
  logic [1:0] b_scope;
  logic [5:0] b_fm;
  logic [SW-1:0] b_wd, b_rdat;
  logic [1:0] b_bch;
  logic [2:0] b_bfld;
  logic [4:0] b_bwd, b_brdat;

  xtc_tune_ctrl #(.NUM_CH(NA), .ADDR_W(AW), .BROADCAST(1'b0), .SCOPE_EN(1'b1), .FIELD_EN(6'h3F)) dut (
    .clk(clk), .rst_n(rst_n), .req_wr(a_wr), .req_rd(a_rd), .req_addr(a_addr),
    .req_scope(a_scope), .req_fmask(a_fm), .req_wdata(a_wd),
    .busy(a_busy), .error(a_err), .rd_valid(a_vld), .rd_data(a_rdat),
    .bus_wr(a_bwr), .bus_rd(a_brd), .bus_ch(a_bch), .bus_fld(a_bfld),
    .bus_wdata(a_bwd), .bus_rdata(a_brdat));

  xtc_tune_ctrl #(.NUM_CH(NB), .ADDR_W(AW), .BROADCAST(1'b1), .SCOPE_EN(1'b0), .FIELD_EN(6'h3F)) dut_bc (
    .clk(clk), .rst_n(rst_n), .req_wr(b_wr), .req_rd(b_rd), .req_addr(b_addr),
    .req_scope(b_scope), .req_fmask(b_fm), .req_wdata(b_wd),
    .busy(b_busy), .error(b_err), .rd_valid(b_vld), .rd_data(b_rdat),
    .bus_wr(b_bwr), .bus_rd(b_brd), .bus_ch(b_bch), .bus_fld(b_bfld),
    .bus_wdata(b_bwd), .bus_rdata(b_brdat));

  tb_chan_model #(.NCH(NA), .CW(3)) ma (.clk(clk), .rst_n(rst_n), .bwr(a_bwr), .brd(a_brd),
    .ch(a_bch), .fld(a_bfld), .wd(a_bwd), .rd(a_brdat));
  tb_chan_model #(.NCH(NB), .CW(2)) mb (.clk(clk), .rst_n(rst_n), .bwr(b_bwr), .brd(b_brd),
    .ch(b_bch), .fld(b_bfld), .wd(b_bwd), .rd(b_brdat));

  int n_chk = 0;
  int n_fail = 0;
  logic [4:0] sh_a [NA][6];
  logic [4:0] sh_b [NB][6];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fw(input int i);
    int w [6] = '{3, 5, 5, 5, 3, 4};
    return w[i];
  endfunction
  function automatic int flo(input int i);
    int l [6] = '{0, 3, 8, 13, 18, 21};
    return l[i];
  endfunction
  function automatic logic [4:0] fslice(input logic [SW-1:0] wd, input int i);
    return 5'((wd >> flo(i)) & ((1 << fw(i)) - 1));
  endfunction
  function automatic logic [5:0] scope_m(input bit en, input int s);
    if (!en) return 6'h3F;
    case (s)
      0: return 6'h3F;
      1: return 6'h30;
      2: return 6'h0F;
      default: return 6'h00;
    endcase
  endfunction
  function automatic logic [SW-1:0] pack_a(input int ch, input logic [5:0] em);
    logic [SW-1:0] r = '0;
    for (int i = 0; i < 6; i++) if (em[i]) r |= SW'(sh_a[ch][i]) << flo(i);
    return r;
  endfunction
  function automatic logic [SW-1:0] pack_b(input int ch, input logic [5:0] em);
    logic [SW-1:0] r = '0;
    for (int i = 0; i < 6; i++) if (em[i]) r |= SW'(sh_b[ch][i]) << flo(i);
    return r;
  endfunction
  function automatic bit match_a();
    for (int c = 0; c < NA; c++)
      for (int f = 0; f < 6; f++) if (ma.mem[c][f] !== sh_a[c][f]) return 1'b0;
    return 1'b1;
  endfunction
  function automatic bit match_b();
    for (int c = 0; c < NB; c++)
      for (int f = 0; f < 6; f++) if (mb.mem[c][f] !== sh_b[c][f]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_a(input bit wr, input bit rd, input int addr, input int scope,
                       input logic [5:0] fm, input logic [SW-1:0] wd, input string tag);
    logic [5:0] em;
    bit legal;
    int n;
    int acc0;
    logic [SW-1:0] exp;
    em    = fm & scope_m(1'b1, scope);
    legal = (wr ^ rd) && scope != 3 && addr < NA && em != 0;
    acc0  = ma.n_acc;
    @(negedge clk);
    a_wr = wr; a_rd = rd; a_addr = AW'(addr); a_scope = 2'(scope); a_fm = fm; a_wd = wd;
    @(negedge clk);
    a_wr = 1'b0; a_rd = 1'b0;
    if (!legal) begin
      chk(a_err === 1'b1 && a_busy === 1'b0, "R8", "error cycle 1", {a_busy, a_err}, 1);
      @(negedge clk);
      chk(a_err === 1'b1, "R8", "error cycle 2", a_err, 1);
      @(negedge clk);
      chk(a_err === 1'b0, "R8", "error end", a_err, 0);
      chk(ma.n_acc == acc0, "R8", "no bus access", ma.n_acc, acc0);
    end else begin
      n = 0;
      while (a_busy === 1'b1 && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk(n == (wr ? 6 : 7), wr ? "R3" : "R7", "busy length", n, wr ? 6 : 7);
      if (wr) begin
        for (int i = 0; i < 6; i++) if (em[i]) sh_a[addr][i] = fslice(wd, i);
        chk(match_a(), tag, "channel contents", 0, 1);
      end else begin
        exp = pack_a(addr, em);
        chk(a_vld === 1'b1 && a_rdat === exp, tag, "readback", a_rdat, exp);
        @(negedge clk);
        chk(a_vld === 1'b0, "R7", "strobe one cycle", a_vld, 0);
      end
    end
  endtask

  task automatic run_b(input bit wr, input bit rd, input int addr, input int scope,
                       input logic [5:0] fm, input logic [SW-1:0] wd, input string tag);
    logic [5:0] em;
    bit legal;
    int n;
    int acc0;
    logic [SW-1:0] exp;
    em    = fm & scope_m(1'b0, scope);
    legal = (wr ^ rd) && em != 0 && (wr || addr < NB);
    acc0  = mb.n_acc;
    @(negedge clk);
    b_wr = wr; b_rd = rd; b_addr = AW'(addr); b_scope = 2'(scope); b_fm = fm; b_wd = wd;
    @(negedge clk);
    b_wr = 1'b0; b_rd = 1'b0;
    if (!legal) begin
      chk(b_err === 1'b1 && b_busy === 1'b0, "R8", "bc error cycle 1", {b_busy, b_err}, 1);
      @(negedge clk);
      chk(b_err === 1'b1, "R8", "bc error cycle 2", b_err, 1);
      @(negedge clk);
      chk(b_err === 1'b0 && mb.n_acc == acc0, "R8", "bc error end", mb.n_acc, acc0);
    end else begin
      n = 0;
      while (b_busy === 1'b1 && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk(n == (wr ? 6 * NB : 7), wr ? "R4" : "R7", "bc busy length", n, wr ? 6 * NB : 7);
      if (wr) begin
        for (int c = 0; c < NB; c++)
          for (int i = 0; i < 6; i++) if (em[i]) sh_b[c][i] = fslice(wd, i);
        chk(match_b(), tag, "bc all channels", 0, 1);
      end else begin
        exp = pack_b(addr, em);
        chk(b_vld === 1'b1 && b_rdat === exp, tag, "bc readback", b_rdat, exp);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240607);
    a_wr = 0; a_rd = 0; a_addr = '0; a_scope = '0; a_fm = '0; a_wd = '0;
    b_wr = 0; b_rd = 0; b_addr = '0; b_scope = '0; b_fm = '0; b_wd = '0;
    for (int c = 0; c < NA; c++) for (int f = 0; f < 6; f++) sh_a[c][f] = '0;
    for (int c = 0; c < NB; c++) for (int f = 0; f < 6; f++) sh_b[c][f] = '0;
    repeat (3) @(negedge clk);
    chk({a_busy, a_err, a_vld, a_bwr, a_brd} === 5'b0, "R1", "outputs in reset",
        {a_busy, a_err, a_vld, a_bwr, a_brd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({a_busy, a_err, a_vld, a_bwr, a_brd, b_busy, b_err} === 7'b0, "R1", "idle after reset",
        {a_busy, a_err, a_vld, a_bwr, a_brd, b_busy, b_err}, 0);

    // R3 addressed write, full field set, then R7 readback
    run_a(1, 0, 3, 0, 6'h3F, 25'h1ABCDEF, "R3");
    run_a(0, 1, 3, 0, 6'h3F, '0, "R7");
    // R5 partial mask write and read
    run_a(1, 0, 0, 0, 6'b000101, 25'h1FFFFFF, "R5");
    run_a(0, 1, 0, 0, 6'h3F, '0, "R5");
    run_a(0, 1, 3, 0, 6'b100010, '0, "R5");
    // R6 scope selection
    run_a(1, 0, 7, 1, 6'h3F, 25'h0F0F0F0, "R6");
    run_a(1, 0, 6, 2, 6'h3F, 25'h1234567, "R6");
    run_a(0, 1, 7, 2, 6'h3F, '0, "R6");
    run_a(0, 1, 7, 1, 6'h3F, '0, "R6");
    // R8 illegal requests
    run_a(1, 1, 2, 0, 6'h3F, '0, "R8");
    run_a(1, 0, 2, 3, 6'h3F, '0, "R8");
    run_a(1, 0, 8, 0, 6'h3F, '0, "R8");
    run_a(0, 1, 511, 0, 6'h3F, '0, "R8");
    run_a(1, 0, 2, 0, 6'h00, '0, "R8");
    run_a(1, 0, 2, 1, 6'h0F, '0, "R8");

    // R2 request held while busy is ignored
    @(negedge clk);
    a_wr = 1; a_rd = 0; a_addr = 9'd1; a_scope = 2'd0; a_fm = 6'h3F; a_wd = 25'h0AAAAAA;
    @(negedge clk);
    chk(a_busy === 1'b1, "R2", "busy after accept", a_busy, 1);
    a_addr = 9'd2; a_wd = 25'h1555555;
    @(negedge clk);
    a_wr = 0;
    while (a_busy === 1'b1) @(negedge clk);
    for (int i = 0; i < 6; i++) sh_a[1][i] = fslice(25'h0AAAAAA, i);
    chk(match_a(), "R2", "second request ignored", 0, 1);

    // random mix on the addressed build
    for (int k = 0; k < 60; k++) begin
      int r;
      bit wr;
      bit rd;
      r  = int'($urandom % 8);
      wr = (r == 0) || (r >= 4);
      rd = (r <= 3);
      run_a(wr, rd, int'($urandom % 10), int'($urandom % 4), 6'($urandom),
            SW'($urandom), wr ? "R3" : "R7");
    end

    // R4 broadcast build, scope input ignored (R6) and address ignored on writes
    run_b(1, 0, 300, 3, 6'h3F, 25'h1357BDF, "R4");
    run_b(0, 1, 2, 0, 6'h3F, '0, "R4");
    run_b(1, 0, 0, 1, 6'b001001, 25'h0000000, "R6");
    run_b(0, 1, 1, 2, 6'h3F, '0, "R6");
    run_b(0, 1, 4, 0, 6'h3F, '0, "R8");
    for (int k = 0; k < 15; k++) begin
      bit wr;
      wr = ($urandom % 2) == 0;
      run_b(wr, !wr, int'($urandom % 6), int'($urandom % 4), 6'($urandom),
            SW'($urandom), wr ? "R4" : "R7");
    end

    chk(ma.n_both == 0 && mb.n_both == 0, "R9", "read and write together",
        ma.n_both + mb.n_both, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule